// File: doc/BRIEF.md
# Spatial Dither Unit for Pixel Depth Reduction

This block takes a stream of 12-bit-per-channel RGB pixels and reduces each channel to 8 or 6 bits. Before the low bits are dropped, a small amount of pseudo-random noise is added so that smooth gradients show fine grain instead of visible banding. The noise comes from 28-bit linear feedback shift registers. All three channels can share one generator, or each channel can have its own generator with a different feedback tap. An optional high-pass shaping of the noise moves its energy towards higher spatial frequencies.

Seeds are loaded when the unit is switched on. If frame-random mode is selected, the seeds are also reloaded at every frame start, mixed with a 4-bit frame counter so that successive frames get different noise. When the enable is low, or when an unsupported depth code is selected, the unit only truncates.

Top module: `spatial_dither`

## Requirements
- R1: The output is registered one cycle after the input. `outValid` equals `pixValid` from the previous cycle. After reset, `outValid` and all output channels are 0.
- R2: `depthSel` = 0 gives 6-bit results in `out*[5:0]` with `out*[7:6]` = 0, so 6 bits are discarded. `depthSel` = 1 gives 8-bit results, so 4 bits are discarded.
- R3: With `ditherEn` = 0, each output is the input shifted right by the discarded-bit count, with no noise added.
- R4: `depthSel` = 2 or 3 is not supported. The dither stays off and each output is the input's top 8 bits.
- R5: Each generator is a Fibonacci LFSR that shifts left. Its new bit 0 is `s[27] ^ s[k-1]` for a polynomial x^28 + x^k + 1. It advances once for every cycle in which `pixValid` and `ditherEn` are both 1.
- R6: With `rgbRandom` = 0, all channels take noise from the red generator (red seed, k = 3). With `rgbRandom` = 1, red, green and blue use their own seeds with k = 3, 9 and 13.
- R7: The seeds are loaded in the first enabled cycle after reset or after `ditherEn` was 0. With `frameRandom` = 1, they are also reloaded on each `frameStart` while the unit is enabled. A load takes priority over an advance, and a pixel in the load cycle uses the state from before the load.
- R8: With `frameRandom` = 1, a frame counter counts enabled `frameStart` pulses and wraps from 15 to 0. The value loaded is `seed ^ (count << 4)`, using the count from before the increment. With `frameRandom` = 0, the counter is held at 0 and nothing is mixed into the seed.
- R9: A loaded value of zero is replaced by 1.
- R10: With `d` discarded bits and generator state `L`, the plain noise is `L[d-1:0]`. With `highPass` = 1, the noise is `(L[d-1:0] + 2^d - L[d:1]) >> 1`, which uses the previous state's low bits.
- R11: The noise is added to the 12-bit input, the sum saturates at 4095, and the result is then shifted right by `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ditherEn | input | 1 | Dither enable |
| depthSel | input | 2 | 0: 6-bit, 1: 8-bit, 2/3: unsupported |
| rgbRandom | input | 1 | Per-channel generators when 1 |
| frameRandom | input | 1 | Reseed on every frame start when 1 |
| highPass | input | 1 | High-pass noise shaping |
| seedR | input | 28 | Red seed |
| seedG | input | 28 | Green seed |
| seedB | input | 28 | Blue seed |
| frameStart | input | 1 | Frame-start strobe |
| pixValid | input | 1 | Input pixel valid |
| pixR | input | 12 | Red input |
| pixG | input | 12 | Green input |
| pixB | input | 12 | Blue input |
| outValid | output | 1 | Output pixel valid |
| outR | output | 8 | Red output |
| outG | output | 8 | Green output |
| outB | output | 8 | Blue output |

## Verification
The hardest condition to reach from the ports is the frame counter wrapping from 15 back to 0 while reseeding is active. A wrong mix or a wrong wrap only changes the noise after many frames, and even then only slightly. The stimulus runs more than sixteen short frames with pixels between the strobes, and a behavioural generator model is compared with every output pixel. The stimulus also covers a load coinciding with a valid pixel, and seeds that mix to zero.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int MIX_W = 4;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic             active;
    logic             deep;
    logic             highPass;
    logic             shared;
    logic [MIX_W-1:0] mix;
  } ditherCtl_t;
endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
#(
  parameter int FRAME_MAX = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ditherEn,
  input  logic [1:0] depthSel,
  input  logic       rgbRandom,
  input  logic       frameRandom,
  input  logic       highPass,
  input  logic       frameStart,
  input  logic       pixValid,
  output ditherCtl_t ctl
);
  logic             enQ;
  logic [MIX_W-1:0] frameCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      frameCnt <= '0;
    end else begin
      enQ <= ditherEn;
      if (!frameRandom)
        frameCnt <= '0;
      else if (ditherEn && frameStart)
        frameCnt <= (frameCnt == MIX_W'(FRAME_MAX)) ? '0 : frameCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load     = ditherEn && (!enQ || (frameRandom && frameStart));
    ctl.advance  = ditherEn && pixValid;
    ctl.active   = ditherEn && !depthSel[1];
    ctl.deep     = (depthSel != 2'd0);
    ctl.highPass = highPass;
    ctl.shared   = !rgbRandom;
    ctl.mix      = frameRandom ? frameCnt : '0;
  end
endmodule

// File: rtl/dither_datapath.sv
module dither_datapath
  import dither_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int OUT_W     = 8,
  parameter int LOW_W     = 6,
  parameter int LFSR_W    = 28,
  parameter int MIX_SHIFT = 4,
  parameter int TAP_R     = 3,
  parameter int TAP_G     = 9,
  parameter int TAP_B     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ditherCtl_t        ctl,
  input  logic              pixValid,
  input  logic [IN_W-1:0]   pixR,
  input  logic [IN_W-1:0]   pixG,
  input  logic [IN_W-1:0]   pixB,
  input  logic [LFSR_W-1:0] seedR,
  input  logic [LFSR_W-1:0] seedG,
  input  logic [LFSR_W-1:0] seedB,
  output logic              outValid,
  output logic [OUT_W-1:0]  outR,
  output logic [OUT_W-1:0]  outG,
  output logic [OUT_W-1:0]  outB
);
  localparam int SUM_W      = IN_W + 1;
  localparam int DEEP_DROP  = IN_W - OUT_W;
  localparam int SHAL_DROP  = IN_W - LOW_W;
  localparam int SH_W       = $clog2(IN_W + 1);

  logic [2:0][IN_W-1:0]   pix;
  logic [2:0][LFSR_W-1:0] seed;
  logic [2:0][LFSR_W-1:0] state;
  logic [2:0][OUT_W-1:0]  res;
  logic [SUM_W-1:0]       mask;
  logic [SUM_W-1:0]       unitVal;
  logic [SH_W-1:0]        dropAmt;

  assign pix  = {pixB, pixG, pixR};
  assign seed = {seedB, seedG, seedR};

  always_comb begin
    dropAmt = ctl.deep ? SH_W'(DEEP_DROP) : SH_W'(SHAL_DROP);
    unitVal = SUM_W'(1) << dropAmt;
    mask    = unitVal - SUM_W'(1);
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    localparam int TAP = (ch == 0) ? TAP_R : (ch == 1) ? TAP_G : TAP_B;
    logic [LFSR_W-1:0] mixed, loadVal, stepped, src;
    logic [SUM_W-1:0]  curBits, prevBits, shaped, noise, sum;
    logic [IN_W-1:0]   clipped;

    assign mixed   = seed[ch] ^ (LFSR_W'(ctl.mix) << MIX_SHIFT);
    assign loadVal = (mixed == '0) ? LFSR_W'(1) : mixed;
    assign stepped = {state[ch][LFSR_W-2:0], state[ch][LFSR_W-1] ^ state[ch][TAP-1]};

    always_ff @(posedge clk) begin
      if (!rstN)            state[ch] <= LFSR_W'(1);
      else if (ctl.load)    state[ch] <= loadVal;
      else if (ctl.advance) state[ch] <= stepped;
    end

    always_comb begin
      src      = ctl.shared ? state[0] : state[ch];
      curBits  = src[SUM_W-1:0] & mask;
      prevBits = src[SUM_W:1] & mask;
      shaped   = (curBits + unitVal - prevBits) >> 1;
      if (!ctl.active)       noise = '0;
      else if (ctl.highPass) noise = shaped;
      else                   noise = curBits;
      sum      = {1'b0, pix[ch]} + noise;
      clipped  = sum[SUM_W-1] ? '1 : sum[IN_W-1:0];
      res[ch]  = OUT_W'(clipped >> dropAmt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outR     <= '0;
      outG     <= '0;
      outB     <= '0;
    end else begin
      outValid <= pixValid;
      outR     <= res[0];
      outG     <= res[1];
      outB     <= res[2];
    end
  end
endmodule

// File: rtl/spatial_dither.sv
module spatial_dither
  import dither_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int OUT_W     = 8,
  parameter int LOW_W     = 6,
  parameter int LFSR_W    = 28,
  parameter int FRAME_MAX = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ditherEn,
  input  logic [1:0]        depthSel,
  input  logic              rgbRandom,
  input  logic              frameRandom,
  input  logic              highPass,
  input  logic [LFSR_W-1:0] seedR,
  input  logic [LFSR_W-1:0] seedG,
  input  logic [LFSR_W-1:0] seedB,
  input  logic              frameStart,
  input  logic              pixValid,
  input  logic [IN_W-1:0]   pixR,
  input  logic [IN_W-1:0]   pixG,
  input  logic [IN_W-1:0]   pixB,
  output logic              outValid,
  output logic [OUT_W-1:0]  outR,
  output logic [OUT_W-1:0]  outG,
  output logic [OUT_W-1:0]  outB
);
  ditherCtl_t ctl;

  dither_ctrl #(.FRAME_MAX(FRAME_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .ditherEn(ditherEn), .depthSel(depthSel),
    .rgbRandom(rgbRandom), .frameRandom(frameRandom), .highPass(highPass),
    .frameStart(frameStart), .pixValid(pixValid), .ctl(ctl)
  );

  dither_datapath #(
    .IN_W(IN_W), .OUT_W(OUT_W), .LOW_W(LOW_W), .LFSR_W(LFSR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixValid(pixValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .seedR(seedR), .seedG(seedG), .seedB(seedB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );
endmodule

// File: rtl/spatial_dither_checker.sv
module spatial_dither_checker #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ditherEn,
  input logic [1:0]       depthSel,
  input logic             pixValid,
  input logic [IN_W-1:0]  pixR,
  input logic             outValid,
  input logic [OUT_W-1:0] outR,
  input logic [OUT_W-1:0] outG,
  input logic [OUT_W-1:0] outB
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);
  a_r2_narrow_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && depthSel == 2'd0) |=>
      (outR[OUT_W-1:OUT_W-2] == 2'b00 && outG[OUT_W-1:OUT_W-2] == 2'b00 &&
       outB[OUT_W-1:OUT_W-2] == 2'b00));
  a_r3_bypass_truncates: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !ditherEn && depthSel == 2'd1) |=>
      (outR == $past(pixR[IN_W-1 -: OUT_W])));
  a_r4_unsupported_depth: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && depthSel[1]) |=> (outR == $past(pixR[IN_W-1 -: OUT_W])));
  a_r11_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && ditherEn && depthSel == 2'd1 && pixR == '1) |=> (outR == '1));
endmodule

bind spatial_dither spatial_dither_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) i_checker (
  .clk(clk), .rstN(rstN), .ditherEn(ditherEn), .depthSel(depthSel),
  .pixValid(pixValid), .pixR(pixR), .outValid(outValid),
  .outR(outR), .outG(outG), .outB(outB)
);

// File: tb/test_spatial_dither.sv
`timescale 1ns/1ps
module test_spatial_dither;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ditherEn = 1'b0, rgbRandom = 1'b0, frameRandom = 1'b0, highPass = 1'b0;
  logic [1:0] depthSel = 2'd1;
  logic [27:0] seedR = '0, seedG = '0, seedB = '0;
  logic frameStart = 1'b0, pixValid = 1'b0;
  logic [11:0] pixR = '0, pixG = '0, pixB = '0;
  logic outValid;
  logic [7:0] outR, outG, outB;

  int checks = 0;
  int errors = 0;
  int lf[3];
  int frameCnt = 0;
  bit enQ = 0;
  int unsigned rng = 32'h1234_5678;
  int expV, expR, expG, expB;

  always #2.5 clk = ~clk;

  spatial_dither i_spatial_dither (
    .clk(clk), .rstN(rstN), .ditherEn(ditherEn), .depthSel(depthSel),
    .rgbRandom(rgbRandom), .frameRandom(frameRandom), .highPass(highPass),
    .seedR(seedR), .seedG(seedG), .seedB(seedB), .frameStart(frameStart),
    .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  function automatic int tapOf(int c);
    return (c == 0) ? 3 : (c == 1) ? 9 : 13;
  endfunction

  function automatic int advanceLfsr(int s, int k);
    int nb;
    nb = ((s >> 27) ^ (s >> (k - 1))) & 1;
    return ((s << 1) & 32'h0FFF_FFFF) | nb;
  endfunction

  function automatic int modelPixel(int pix, int src);
    int d, mask, cur, prev, n, s;
    d = (depthSel == 2'd0) ? 6 : 4;
    mask = (1 << d) - 1;
    cur = src & mask;
    prev = (src >> 1) & mask;
    n = highPass ? ((cur + (1 << d) - prev) >> 1) : cur;
    if (!(ditherEn && depthSel < 2)) n = 0;
    s = pix + n;
    if (s > 4095) s = 4095;
    return s >> d;
  endfunction

  function automatic int unsigned nextRand();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng >> 8;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: expected values from the current inputs and the model, model update, compare.
  task automatic tick(string tag);
    int seeds[3];
    int mix;
    bit ld;
    seeds[0] = seedR; seeds[1] = seedG; seeds[2] = seedB;
    expV = pixValid;
    expR = modelPixel(pixR, lf[0]);
    expG = modelPixel(pixG, rgbRandom ? lf[1] : lf[0]);
    expB = modelPixel(pixB, rgbRandom ? lf[2] : lf[0]);
    ld = ditherEn && (!enQ || (frameRandom && frameStart));
    mix = frameRandom ? frameCnt : 0;
    for (int c = 0; c < 3; c++) begin
      if (ld) begin
        lf[c] = (seeds[c] ^ (mix << 4)) & 32'h0FFF_FFFF;
        if (lf[c] == 0) lf[c] = 1;
      end else if (ditherEn && pixValid) begin
        lf[c] = advanceLfsr(lf[c], tapOf(c));
      end
    end
    if (!frameRandom) frameCnt = 0;
    else if (ditherEn && frameStart) frameCnt = (frameCnt == 15) ? 0 : frameCnt + 1;
    enQ = ditherEn;
    @(negedge clk);
    check({tag, " valid"}, int'(outValid), expV);
    if (expV != 0) begin
      check({tag, " red"}, int'(outR), expR);
      check({tag, " green"}, int'(outG), expG);
      check({tag, " blue"}, int'(outB), expB);
    end
  endtask

  task automatic randPix();
    pixR = 12'(nextRand());
    pixG = 12'(nextRand());
    pixB = 12'(nextRand());
  endtask

  task automatic stream(string tag, int n);
    for (int i = 0; i < n; i++) begin
      pixValid = ((nextRand() & 7) != 0);
      randPix();
      tick(tag);
    end
    pixValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) lf[c] = 1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(outValid), 0);
    check("R1 reset data", int'(outR), 0);
    rstN = 1'b1;

    // Bypass: plain truncation
    ditherEn = 1'b0; depthSel = 2'd1;
    stream("R3 bypass", 20);
    pixValid = 1'b1; pixR = 12'hABC; tick("R3 bypass");
    check("R3 explicit", int'(outR), 8'hAB);

    // Unsupported depth
    ditherEn = 1'b1; depthSel = 2'd2;
    seedR = 28'h0ACE123; seedG = 28'h1234567; seedB = 28'h7654321;
    stream("R4 depth2", 20);
    depthSel = 2'd3;
    pixValid = 1'b1; pixR = 12'h5F7; tick("R4 depth3");
    check("R4 explicit", int'(outR), 8'h5F);

    // Shared generator, 8-bit
    ditherEn = 1'b0; tick("R7 off");
    ditherEn = 1'b1; depthSel = 2'd1; rgbRandom = 1'b0;
    stream("R5 R6 shared", 40);

    // Per-channel generators, reload via enable toggle
    ditherEn = 1'b0; tick("R7 off");
    ditherEn = 1'b1; rgbRandom = 1'b1;
    pixValid = 1'b1; randPix(); tick("R7 load cycle pixel");
    stream("R6 per channel", 40);

    // 6-bit depth
    depthSel = 2'd0;
    stream("R2 six bit", 40);

    // High-pass shaping both depths
    highPass = 1'b1;
    stream("R10 highpass six", 30);
    depthSel = 2'd1;
    stream("R10 highpass eight", 30);
    highPass = 1'b0;

    // Saturation
    pixValid = 1'b1; pixR = 12'hFFF; pixG = 12'hFFF; pixB = 12'hFFE;
    tick("R11 saturate");
    check("R11 explicit red", int'(outR), 255);

    // Frame-random reseeding across counter wrap
    frameRandom = 1'b1;
    for (int f = 0; f < 20; f++) begin
      frameStart = 1'b1; pixValid = (f % 3 == 0); randPix();
      tick("R8 frame start");
      frameStart = 1'b0;
      stream("R8 frame body", 7);
    end
    highPass = 1'b1; depthSel = 2'd0;
    for (int f = 0; f < 4; f++) begin
      frameStart = 1'b1; tick("R7 frame reload");
      frameStart = 1'b0;
      stream("R7 frame body", 5);
    end
    highPass = 1'b0; depthSel = 2'd1;

    // Frame random cleared: counter held, no reload on strobe
    frameRandom = 1'b0;
    frameStart = 1'b1; tick("R8 no reload"); frameStart = 1'b0;
    stream("R8 no mix", 20);

    // Zero seeds replaced by one
    ditherEn = 1'b0; tick("R9 off");
    seedR = '0; seedG = '0; seedB = '0;
    ditherEn = 1'b1;
    stream("R9 zero seed", 30);
    frameRandom = 1'b1;
    seedR = 28'h10; seedG = 28'h20; seedB = 28'h30;
    for (int f = 0; f < 5; f++) begin
      frameStart = 1'b1; tick("R9 mixed zero"); frameStart = 1'b0;
      stream("R9 mixed body", 4);
    end

    tick("R1 drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule